// File: doc/BRIEF.md
# Debug Exception Status Register

This block holds the status word a processor core keeps for its debug mode. When the core takes a debug exception, the block records several things: why the exception happened, whether the trapped instruction sat in a branch delay slot, and whether the core was halted or dozing. While the core is in debug mode, it can take an ordinary exception. In that case the block records the exception code and the delay-slot flag, and clears the debug cause flags. A debug-return strobe takes the core back out of debug mode.

The decision to take an exception, vectoring and the return instruction all sit outside the block and arrive as one-cycle strobes. All state is registered. The read port is a combinational view of that state. Every event therefore shows on the read port in the cycle after the clock edge that samples it.

In debug mode, software may rewrite the six cause flags through a narrow write port. Outside debug mode, the read port exposes only the mode bit and a constant version field.

Top module: `dbg_status_reg`

## Requirements
- R1: After reset the core is out of debug mode, every stored field is zero, and the read word equals the version parameter placed at bits 17:15 (default 3'd2).
- R2: A debug-exception strobe taken outside debug mode sets the mode bit (read bit 30) from the next cycle. A debug-return strobe while in debug mode clears it from the next cycle.
- R3: On a debug exception, the cause flags (read bits 5:0) are loaded with only the lowest-numbered set bit of the cause input. They become zero if no cause bit is set.
- R4: An exception strobe taken while in debug mode clears the cause flags and loads the 5-bit exception code at read bits 14:10.
- R5: A debug exception leaves the exception code unchanged.
- R6: The halt flag (bit 26) and doze flag (bit 27) are loaded only on a debug exception. An exception inside debug mode leaves them unchanged.
- R7: The branch-delay flag (bit 31) is loaded from the delay input on both kinds of event.
- R8: Outside debug mode, the read word carries only the mode bit and the version field; every other bit reads zero.
- R9: In debug mode, a write replaces the cause flags with the write data. When an exception in debug mode arrives in the same cycle, the exception wins over the write.
- R10: A write issued outside debug mode changes nothing.
- R11: A debug-exception strobe while already in debug mode, and an in-debug exception strobe outside debug mode, are both ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_exc_i | input | 1 | Debug exception taken this cycle |
| nest_exc_i | input | 1 | Ordinary exception taken while in debug mode |
| dret_i | input | 1 | Debug return executed |
| cause_i | input | 6 | Debug cause flags, bit 0 lowest priority index |
| exc_code_i | input | 5 | Exception code for an exception inside debug mode |
| in_delay_i | input | 1 | Excepting instruction was in a branch delay slot |
| halted_i | input | 1 | Core clock was stopped when the debug exception came |
| dozing_i | input | 1 | Core was in low-power state when the debug exception came |
| wr_en_i | input | 1 | Write strobe for the cause flags |
| wr_data_i | input | 6 | New cause flag values |
| rd_data_o | output | 32 | Status word as seen by a read |
| dbg_mode_o | output | 1 | Debug mode flag |

## Verification
Each strobe or write is sampled on one rising edge and lands in a register. The read word is a combinational view of those registers, so every result is due exactly one cycle after the stimulus. The driver applies each stimulus at a falling edge and pushes the word the requirements predict for the next rising edge. The monitor pops that word one time unit after the rising edge and compares it there, which keeps every comparison on the cycle where its result is due. Cases where two events or an event and a write share a cycle get the same one-cycle timing, so priority errors show up directly.

// File: rtl/dbgst_pkg.sv
package dbgst_pkg;
  localparam int WORD_W  = 32;
  localparam int CAUSE_W = 6;
  localparam int CODE_W  = 5;
  localparam int VER_W   = 3;

  // Field placement in the status word (decoded by software)
  localparam int POS_CAUSE = 0;
  localparam int POS_CODE  = 10;
  localparam int POS_VER   = 15;
  localparam int POS_HALT  = 26;
  localparam int POS_DOZE  = 27;
  localparam int POS_MODE  = 30;
  localparam int POS_DBD   = 31;
endpackage

// File: rtl/dbgst_rst_sync.sv
module dbgst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dbgst_event_ctl.sv
module dbgst_event_ctl
  import dbgst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_exc_i,
  input  logic              nest_exc_i,
  input  logic              dret_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              in_delay_i,
  input  logic              halted_i,
  input  logic              dozing_i,
  output logic              dbg_ld_o,
  output logic              nest_ld_o,
  output logic              dm_o,
  output logic [CODE_W-1:0] code_o,
  output logic              dbd_o,
  output logic              halt_o,
  output logic              doze_o
);
  logic              dm_q, dm_d, dm_en;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  logic              dbd_q, dbd_d, dbd_en;
  logic              halt_q, halt_d, doze_q, doze_d, hd_en;
  logic              dbg_ld, nest_ld;

  // Qualify strobes against current mode
  assign dbg_ld  = dbg_exc_i & ~dm_q;
  assign nest_ld = nest_exc_i & dm_q;

  always_comb begin
    dm_en   = dbg_ld | (dret_i & dm_q);
    dm_d    = dbg_ld;
    code_en = nest_ld;
    code_d  = exc_code_i;
    dbd_en  = dbg_ld | nest_ld;
    dbd_d   = in_delay_i;
    hd_en   = dbg_ld;
    halt_d  = halted_i;
    doze_d  = dozing_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q   <= 1'b0;
      code_q <= '0;
      dbd_q  <= 1'b0;
      halt_q <= 1'b0;
      doze_q <= 1'b0;
    end else begin
      if (dm_en)   dm_q   <= dm_d;
      if (code_en) code_q <= code_d;
      if (dbd_en)  dbd_q  <= dbd_d;
      if (hd_en) begin
        halt_q <= halt_d;
        doze_q <= doze_d;
      end
    end
  end

  assign dbg_ld_o  = dbg_ld;
  assign nest_ld_o = nest_ld;
  assign dm_o      = dm_q;
  assign code_o    = code_q;
  assign dbd_o     = dbd_q;
  assign halt_o    = halt_q;
  assign doze_o    = doze_q;

  AST_ENTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc_i && !dm_q) |=> dm_q); // R2
  AST_LEAVE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dret_i && dm_q) |=> !dm_q); // R2
  AST_CODE_HELD_ON_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc_i && !dm_q) |=> $stable(code_q)); // R5
  AST_HALT_DOZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_exc_i && dm_q) |=> ($stable(halt_q) && $stable(doze_q))); // R6
  AST_DBD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbg_exc_i && !dm_q) || (nest_exc_i && dm_q)) |=> (dbd_q == $past(in_delay_i))); // R7
  AST_STRAY_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_exc_i && !dm_q) |=> $stable(code_q)); // R11
  AST_STRAY_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc_i && dm_q && !dret_i) |=> (dm_q && $stable(halt_q))); // R11
endmodule

// File: rtl/dbgst_cause_bank.sv
module dbgst_cause_bank
  import dbgst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_ld_i,
  input  logic               nest_ld_i,
  input  logic               wr_ok_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  output logic [CAUSE_W-1:0] flags_o
);
  logic [CAUSE_W:0]   seen;
  logic [CAUSE_W-1:0] pick;
  logic [CAUSE_W-1:0] flags_q, flags_d;
  logic               flags_en;

  // Keep only the lowest-numbered active cause
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_prio
    assign pick[i]   = cause_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | cause_i[i];
  end

  always_comb begin
    flags_en = dbg_ld_i | nest_ld_i | wr_ok_i;
    if (dbg_ld_i)       flags_d = pick;
    else if (nest_ld_i) flags_d = '0;
    else                flags_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ld_i |=> $onehot0(flags_q)); // R3
  AST_CAUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    nest_ld_i |=> (flags_q == '0)); // R4
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_i && !dbg_ld_i && !nest_ld_i) |=> (flags_q == $past(wr_data_i))); // R9
endmodule

// File: rtl/dbgst_read_view.sv
module dbgst_read_view
  import dbgst_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 3'd2
) (
  input  logic               dm_i,
  input  logic               dbd_i,
  input  logic               halt_i,
  input  logic               doze_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [CAUSE_W-1:0] flags_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [WORD_W-1:0] always_vis;
  logic [WORD_W-1:0] mode_vis;

  always_comb begin
    always_vis = '0;
    always_vis[POS_MODE] = dm_i;
    always_vis[POS_VER +: VER_W] = VERSION;

    mode_vis = '0;
    mode_vis[POS_DBD]  = dbd_i;
    mode_vis[POS_DOZE] = doze_i;
    mode_vis[POS_HALT] = halt_i;
    mode_vis[POS_CODE +: CODE_W]   = code_i;
    mode_vis[POS_CAUSE +: CAUSE_W] = flags_i;

    word_o = always_vis | (dm_i ? mode_vis : '0);
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbgst_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 3'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_exc_i,
  input  logic               nest_exc_i,
  input  logic               dret_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CODE_W-1:0]  exc_code_i,
  input  logic               in_delay_i,
  input  logic               halted_i,
  input  logic               dozing_i,
  input  logic               wr_en_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               dbg_mode_o
);
  logic               rst_q_n;
  logic               dbg_ld, nest_ld, wr_ok;
  logic               dm, dbd, halt, doze;
  logic [CODE_W-1:0]  code;
  logic [CAUSE_W-1:0] flags;

  dbgst_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  dbgst_event_ctl u_evt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .dbg_exc_i  (dbg_exc_i),
    .nest_exc_i (nest_exc_i),
    .dret_i     (dret_i),
    .exc_code_i (exc_code_i),
    .in_delay_i (in_delay_i),
    .halted_i   (halted_i),
    .dozing_i   (dozing_i),
    .dbg_ld_o   (dbg_ld),
    .nest_ld_o  (nest_ld),
    .dm_o       (dm),
    .code_o     (code),
    .dbd_o      (dbd),
    .halt_o     (halt),
    .doze_o     (doze)
  );

  // Writes only count in debug mode; events take priority
  assign wr_ok = wr_en_i & dm & ~nest_ld & ~dbg_ld;

  dbgst_cause_bank u_cause (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .dbg_ld_i  (dbg_ld),
    .nest_ld_i (nest_ld),
    .wr_ok_i   (wr_ok),
    .cause_i   (cause_i),
    .wr_data_i (wr_data_i),
    .flags_o   (flags)
  );

  dbgst_read_view #(.VERSION(VERSION)) u_view (
    .dm_i    (dm),
    .dbd_i   (dbd),
    .halt_i  (halt),
    .doze_i  (doze),
    .code_i  (code),
    .flags_i (flags),
    .word_o  (rd_data_o)
  );

  assign dbg_mode_o = dm;

  AST_HIDDEN_FIELDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dbg_mode_o |-> ((rd_data_o[POS_CODE +: CODE_W] == '0) && (rd_data_o[POS_CAUSE +: CAUSE_W] == '0)
                     && !rd_data_o[POS_HALT] && !rd_data_o[POS_DBD])); // R8
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en_i && !dm && !dbg_exc_i) |=> $stable(flags)); // R10
  AST_VERSION_FIELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_data_o[POS_VER +: VER_W] == VERSION); // R1
endmodule

// File: tb/sim_dbg_status_reg.sv
module sim_dbg_status_reg;
  localparam int PERIOD = 10;
  localparam logic [2:0] VER = 3'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_exc_i, nest_exc_i, dret_i;
  logic [5:0]  cause_i;
  logic [4:0]  exc_code_i;
  logic        in_delay_i, halted_i, dozing_i, wr_en_i;
  logic [5:0]  wr_data_i;
  logic [31:0] rd_data_o;
  logic        dbg_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  logic       m_dm, m_dbd, m_halt, m_doze;
  logic [5:0] m_cause;
  logic [4:0] m_code;

  always #(PERIOD/2) clk = ~clk;

  dbg_status_reg #(.VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_exc_i(dbg_exc_i), .nest_exc_i(nest_exc_i),
    .dret_i(dret_i), .cause_i(cause_i), .exc_code_i(exc_code_i),
    .in_delay_i(in_delay_i), .halted_i(halted_i), .dozing_i(dozing_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .dbg_mode_o(dbg_mode_o)
  );

  function automatic logic [5:0] lowest(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 6'(1 << i);
    return 6'd0;
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[30] = m_dm;
    w[17:15] = VER;
    if (m_dm) begin
      w[31] = m_dbd; w[27] = m_doze; w[26] = m_halt;
      w[14:10] = m_code; w[5:0] = m_cause;
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic dx, input logic nx, input logic rt,
                      input logic [5:0] c, input logic [4:0] cd,
                      input logic dl, input logic hl, input logic dz,
                      input logic we, input logic [5:0] wd, input string req);
    logic dq, nq, wq;
    @(negedge clk);
    dbg_exc_i = dx; nest_exc_i = nx; dret_i = rt; cause_i = c; exc_code_i = cd;
    in_delay_i = dl; halted_i = hl; dozing_i = dz; wr_en_i = we; wr_data_i = wd;
    dq = dx && !m_dm;
    nq = nx && m_dm;
    wq = we && m_dm && !nq;
    if (dq) begin
      m_cause = lowest(c); m_dbd = dl; m_halt = hl; m_doze = dz;
    end else if (nq) begin
      m_cause = '0; m_code = cd; m_dbd = dl;
    end else if (wq) begin
      m_cause = wd;
    end
    if (dq) m_dm = 1'b1;
    else if (rt && m_dm) m_dm = 1'b0;
    exp_q.push_back(model_word());
    tag_q.push_back(req);
  endtask

  // monitor: one result due per edge after each driven step
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data_o, e);
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dbg_exc_i = 0; nest_exc_i = 0; dret_i = 0; cause_i = 0; exc_code_i = 0;
    in_delay_i = 0; halted_i = 0; dozing_i = 0; wr_en_i = 0; wr_data_i = 0;
    m_dm = 0; m_dbd = 0; m_halt = 0; m_doze = 0; m_cause = 0; m_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset word", rd_data_o, {14'd0, VER, 15'd0});
    check("R1 reset mode", {31'd0, dbg_mode_o}, 32'd0);

    step(0,0,0, 6'h00, 5'd0, 0,0,0, 0, 6'h00, "R8 idle outside mode");
    step(0,0,0, 6'h00, 5'd0, 0,0,0, 1, 6'h3F, "R10 write outside mode");
    step(0,1,0, 6'h00, 5'd5, 1,0,0, 0, 6'h00, "R11 nested strobe outside mode");
    step(1,0,0, 6'b010100, 5'd0, 1,1,0, 0, 6'h00, "R2 R3 R5 R6 R7 debug exception");
    step(1,0,0, 6'b000001, 5'd0, 0,0,1, 0, 6'h00, "R11 debug strobe in mode");
    step(0,1,0, 6'h3F, 5'd13, 0,0,1, 0, 6'h00, "R4 R6 R7 nested exception");
    step(0,0,0, 6'h00, 5'd0, 0,0,0, 1, 6'h3F, "R9 write in mode");
    step(0,1,0, 6'h00, 5'd2, 1,0,0, 1, 6'h15, "R9 nested beats write");
    step(0,0,1, 6'h00, 5'd0, 0,0,0, 0, 6'h00, "R2 R8 debug return");
    step(1,0,0, 6'h00, 5'd0, 0,0,1, 0, 6'h00, "R3 R5 R6 debug exception no cause");
    step(0,0,0, 6'h00, 5'd0, 0,0,0, 1, 6'h2A, "R9 write pattern");
    step(0,0,1, 6'h00, 5'd0, 0,0,0, 0, 6'h00, "R2 second return");
    step(1,0,0, 6'b100000, 5'd0, 1,0,0, 0, 6'h00, "R3 top cause bit");
    step(0,1,0, 6'h00, 5'd31, 1,1,1, 0, 6'h00, "R4 R6 nested max code");
    step(0,0,0, 6'h00, 5'd0, 0,0,0, 0, 6'h00, "R4 idle hold");
    repeat (3) @(negedge clk);
    check("R1 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule